// File: doc/BRIEF.md
# Set/Clear Peripheral Clock Gate Controller

This block holds the enable state of 64 peripheral clocks and drives one gate-enable line per clock. Software controls it through a small 32-bit register bus. For each group of 32 clocks it offers four registers: a set port, a clear port, a readback of the requested state, and a readback of the actual gate state. A 1 written to a set or clear port acts on that one clock only. Zero bits in the same word change nothing, so no read-modify-write sequence or software lock is needed.

The request changes in the cycle of the write. The actual gate state copies the request after a fixed settling delay of `SETTLE_CYCLES` clocks. Software writes a request and then polls the status register until the bit matches. At reset both vectors load `BOOT_MASK`. Its default keeps clock 2, the memory controller clock, running.

Top module: `clk_gate_ctrl`

## Requirements
- R1: A write to a group's set port (group 0 at offset 0x24, group 1 at 0x34) turns on the request bit at every 1 position of the data word. All other request bits are left unchanged.
- R2: A write to a group's clear port (group 0 at 0x28, group 1 at 0x38) turns off the request bit at every 1 position of the data word. All other request bits are left unchanged.
- R3: Clock number n (0 to 63) is in group n/32, at bit n mod 32 of that group's registers, and drives `gate_en[n]`.
- R4: A read of offset 0x2C or 0x3C returns the request vector of group 0 or group 1. A read of 0x30 or 0x40 returns that group's status vector. A read of a set or clear port returns that group's request vector. Any other offset reads as zero. Reads are combinational.
- R5: The status vector equals the request vector delayed by exactly `SETTLE_CYCLES` clock edges (default 4). A request changed at edge k first shows in status after edge k+`SETTLE_CYCLES`.
- R6: `gate_en` always equals the concatenated status vector {group 1, group 0}.
- R7: Reset (active-low `rst_n`, asynchronous) loads `BOOT_MASK` into both the request and the status vectors. The default mask has only bit 2 set.
- R8: Writes to the request and status readback offsets, and to unmapped offsets, change neither the request nor the status.
- R9: A request that is turned on and off again before it settles appears in status as a pulse of the same length. It is neither lost nor stretched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and gate-state clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| gate_en | output | 64 | Settled gate enable, one bit per clock |

## Verification
The bench writes patterns that mix ones and zeros on top of a non-trivial state. A design that did a plain store instead of a bitwise set or clear would disturb the neighbouring clocks. It probes clocks 0, 31, 32 and 63 through both groups to catch a wrong group split or bit swizzle. The gate output is sampled in each cycle around the settle point, so a delay line one stage too short or too long shows up. A two-cycle enable pulse must reappear in the output as exactly two cycles. Writes to the readback offsets and to a stray offset must leave the state alone, and the boot value must keep clock 2 running.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  localparam int ADDR_W     = 8;
  localparam int GRP_W      = 32;
  localparam int NUM_GRP    = 2;
  localparam int NUM_CLK    = GRP_W * NUM_GRP;
  localparam logic [ADDR_W-1:0] GRP_BASE   = 8'h24;
  localparam logic [ADDR_W-1:0] GRP_STRIDE = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SET    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_REQ    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h0C;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_SET,
    RK_CLR,
    RK_REQ,
    RK_STAT
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e kind;
    logic      grp;
  } reg_sel_t;

  // Map a byte offset onto a register kind and group.
  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_t s;
    logic [ADDR_W-1:0] base;
    s.kind = RK_NONE;
    s.grp  = 1'b0;
    for (int g = 0; g < NUM_GRP; g++) begin
      base = GRP_BASE + GRP_STRIDE * ADDR_W'(g);
      if (a == base + OFS_SET)  begin s.kind = RK_SET;  s.grp = g[0]; end
      if (a == base + OFS_CLR)  begin s.kind = RK_CLR;  s.grp = g[0]; end
      if (a == base + OFS_REQ)  begin s.kind = RK_REQ;  s.grp = g[0]; end
      if (a == base + OFS_STAT) begin s.kind = RK_STAT; s.grp = g[0]; end
    end
    return s;
  endfunction

  // Group index of a clock number.
  function automatic int clk_group(input int id);
    return id / GRP_W;
  endfunction

  // Bit position of a clock number inside its group.
  function automatic int clk_bit(input int id);
    return id % GRP_W;
  endfunction

  // New request word after set and clear strobes; clear has priority.
  function automatic logic [GRP_W-1:0] apply_strobes(
      input logic [GRP_W-1:0] cur,
      input logic [GRP_W-1:0] set_m,
      input logic [GRP_W-1:0] clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

  // Read mux for one access.
  function automatic logic [GRP_W-1:0] read_word(
      input reg_sel_t sel,
      input logic [NUM_GRP-1:0][GRP_W-1:0] req,
      input logic [NUM_GRP-1:0][GRP_W-1:0] stat);
    logic [GRP_W-1:0] r;
    case (sel.kind)
      RK_SET, RK_CLR, RK_REQ: r = req[sel.grp];
      RK_STAT:                r = stat[sel.grp];
      default:                r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pcg_decode.sv
module pcg_decode
  import pcg_pkg::*;
(
  input  logic [ADDR_W-1:0]                addr,
  input  logic                             we,
  input  logic [GRP_W-1:0]                 wdata,
  output reg_sel_t                         sel,
  output logic [NUM_GRP-1:0][GRP_W-1:0]    set_mask,
  output logic [NUM_GRP-1:0][GRP_W-1:0]    clr_mask
);

  always_comb begin
    sel = decode_addr(addr);
    for (int g = 0; g < NUM_GRP; g++) begin
      set_mask[g] = (we && sel.kind == RK_SET && sel.grp == g[0]) ? wdata : '0;
      clr_mask[g] = (we && sel.kind == RK_CLR && sel.grp == g[0]) ? wdata : '0;
    end
  end

endmodule

// File: rtl/pcg_bank.sv
module pcg_bank
  import pcg_pkg::*;
#(
  parameter logic [GRP_W-1:0] BOOT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] set_m,
  input  logic [GRP_W-1:0] clr_m,
  output logic [GRP_W-1:0] req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= BOOT;
    else        req <= apply_strobes(req, set_m, clr_m);
  end

  // R1: without a clear strobe, bits only rise where the set strobe had a 1
  p_set_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_m == '0) |=> (((req & ~$past(req)) & ~$past(set_m)) == '0) &&
                      (($past(req) & ~req) == '0));

  // R2: without a set strobe, bits only fall where the clear strobe had a 1
  p_clr_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_m == '0) |=> ((($past(req) & ~req) & ~$past(clr_m)) == '0) &&
                      ((req & ~$past(req)) == '0));

endmodule

// File: rtl/pcg_settle.sv
module pcg_settle
  import pcg_pkg::*;
#(
  parameter int               DEPTH = 4,
  parameter logic [GRP_W-1:0] BOOT  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] req,
  output logic [GRP_W-1:0] stat
);

  localparam int CNT_W = (DEPTH < 1) ? 1 : $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'((DEPTH < 1) ? 0 : DEPTH - 1);

  generate
    if (DEPTH == 0) begin : g_direct
      assign stat = req;
    end else begin : g_chain
      logic [DEPTH-1:0][GRP_W-1:0] stage;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) stage[i] <= BOOT;
        end else begin
          stage[0] <= req;
          for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
      end
      assign stat = stage[DEPTH-1];
    end
  endgenerate

  // Checker state: how many edges the request has held its value
  logic [GRP_W-1:0] req_prev;
  logic [CNT_W-1:0] hold_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev <= BOOT;
      hold_cnt <= CNT_MAX;
    end else begin
      req_prev <= req;
      if (req != req_prev)       hold_cnt <= '0;
      else if (hold_cnt < CNT_MAX) hold_cnt <= hold_cnt + 1'b1;
    end
  end

  // R5: once the request has held for the settle window, status matches it
  p_settled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req == req_prev && hold_cnt == CNT_MAX) |-> (stat == req));

  // R5: status never moves while the request has been steady and settled
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req == req_prev && hold_cnt == CNT_MAX && stat == req) |=> $stable(stat));

endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
  import pcg_pkg::*;
#(
  parameter int                   SETTLE_CYCLES = 4,
  parameter logic [NUM_CLK-1:0]   BOOT_MASK     = 64'h4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [GRP_W-1:0]     bus_wdata,
  output logic [GRP_W-1:0]     bus_rdata,
  output logic [NUM_CLK-1:0]   gate_en
);

  reg_sel_t                      sel;
  logic [NUM_GRP-1:0][GRP_W-1:0] set_mask;
  logic [NUM_GRP-1:0][GRP_W-1:0] clr_mask;
  logic [NUM_GRP-1:0][GRP_W-1:0] req_vec;
  logic [NUM_GRP-1:0][GRP_W-1:0] stat_vec;
  logic                          ro_write;

  pcg_decode u_decode (
    .addr     (bus_addr),
    .we       (bus_we),
    .wdata    (bus_wdata),
    .sel      (sel),
    .set_mask (set_mask),
    .clr_mask (clr_mask)
  );

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      localparam logic [GRP_W-1:0] GRP_BOOT = BOOT_MASK[g*GRP_W +: GRP_W];

      pcg_bank #(.BOOT(GRP_BOOT)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_m (set_mask[g]),
        .clr_m (clr_mask[g]),
        .req   (req_vec[g])
      );

      pcg_settle #(.DEPTH(SETTLE_CYCLES), .BOOT(GRP_BOOT)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_vec[g]),
        .stat  (stat_vec[g])
      );
    end
  endgenerate

  assign gate_en   = stat_vec;
  assign bus_rdata = read_word(sel, req_vec, stat_vec);

  // Named event: a write that lands on a read-only or unmapped offset
  assign ro_write = bus_we && (sel.kind != RK_SET) && (sel.kind != RK_CLR);

  // R8: such a write leaves the request unchanged
  p_ro_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ro_write |=> $stable(req_vec));

  // R3: a set strobe for one group never touches the other group's request
  p_group_iso_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel.kind == RK_SET && !sel.grp) |=> $stable(req_vec[1]));

endmodule

// File: tb/clk_gate_ctrl_test.sv
`timescale 1ns/1ps
module clk_gate_ctrl_test;

  localparam int D = 4;
  localparam logic [63:0] BOOT = 64'h4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] gate_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [63:0] exp_req;

  clk_gate_ctrl #(.SETTLE_CYCLES(D), .BOOT_MASK(BOOT)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gate_en(gate_en)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'hFF;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (D + 1) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(8'h2C, d); check(d == BOOT[31:0],  "R7 req0", {32'h0, d}, BOOT);
    bus_read(8'h30, d); check(d == BOOT[31:0],  "R7 stat0", {32'h0, d}, BOOT);
    bus_read(8'h3C, d); check(d == BOOT[63:32], "R7 req1", {32'h0, d}, 64'h0);
    check(gate_en == BOOT, "R7 R6 gate_en boot", gate_en, BOOT);
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    bus_write(8'h24, 32'hA5A5_0000);  exp_req[31:0] |= 32'hA5A5_0000;
    bus_read(8'h2C, d); check(d == exp_req[31:0], "R1 set group0", {32'h0, d}, exp_req);
    bus_write(8'h24, 32'h0000_0011);  exp_req[31:0] |= 32'h11;
    bus_read(8'h2C, d); check(d == exp_req[31:0], "R1 set keeps others", {32'h0, d}, exp_req);
    bus_write(8'h28, 32'h8400_0010);  exp_req[31:0] &= ~32'h8400_0010;
    bus_read(8'h2C, d); check(d == exp_req[31:0], "R2 clear group0", {32'h0, d}, exp_req);
    bus_write(8'h28, 32'h0);
    bus_read(8'h2C, d); check(d == exp_req[31:0], "R2 zero clear no effect", {32'h0, d}, exp_req);
    settle();
    check(gate_en == exp_req, "R6 gate follows request", gate_en, exp_req);
  endtask

  task automatic t_mapping();
    logic [31:0] d;
    int ids [4] = '{0, 31, 32, 63};
    foreach (ids[i]) begin
      int id = ids[i];
      logic [7:0] base = (id / 32 == 0) ? 8'h24 : 8'h34;
      bus_write(base, 32'h1 << (id % 32));
      exp_req[id] = 1'b1;
      settle();
      check(gate_en[id] == 1'b1, "R3 id on", gate_en, exp_req);
      bus_read(base + 8'h0C, d);
      check(d[id % 32] == 1'b1, "R3 R4 status bit", {32'h0, d}, exp_req);
      bus_write(base + 8'h04, 32'h1 << (id % 32));
      exp_req[id] = 1'b0;
      settle();
      check(gate_en == exp_req, "R3 id off", gate_en, exp_req);
    end
  endtask

  task automatic t_readback();
    logic [31:0] d;
    bus_write(8'h34, 32'h0F0F_0001); exp_req[63:32] |= 32'h0F0F_0001;
    bus_read(8'h3C, d); check(d == exp_req[63:32], "R4 req1 readback", {32'h0, d}, exp_req);
    bus_read(8'h40, d); check(d == 32'h0, "R4 stat1 still old", {32'h0, d}, 64'h0);
    bus_read(8'h34, d); check(d == exp_req[63:32], "R4 set port reads req", {32'h0, d}, exp_req);
    bus_read(8'h28, d); check(d == exp_req[31:0], "R4 clear port reads req", {32'h0, d}, exp_req);
    bus_read(8'h44, d); check(d == 32'h0, "R4 unmapped reads zero", {32'h0, d}, 64'h0);
    settle();
    bus_read(8'h40, d); check(d == exp_req[63:32], "R4 stat1 settled", {32'h0, d}, exp_req);
  endtask

  task automatic t_lag();
    bus_write(8'h24, 32'h20); exp_req[5] = 1'b1;
    for (int k = 1; k <= D + 1; k++) begin
      @(negedge clk);
      #1;
      if (k < D) check(gate_en[5] == 1'b0, "R5 before settle", gate_en, 64'h0);
      else       check(gate_en[5] == 1'b1, "R5 at settle", gate_en, exp_req);
    end
  endtask

  task automatic t_ro_writes();
    logic [31:0] d;
    bus_write(8'h2C, 32'hFFFF_FFFF);
    bus_write(8'h30, 32'hFFFF_FFFF);
    bus_write(8'h40, 32'h0);
    bus_write(8'h50, 32'hFFFF_FFFF);
    bus_read(8'h2C, d); check(d == exp_req[31:0], "R8 req0 unchanged", {32'h0, d}, exp_req);
    bus_read(8'h3C, d); check(d == exp_req[63:32], "R8 req1 unchanged", {32'h0, d}, exp_req);
    settle();
    check(gate_en == exp_req, "R8 gates unchanged", gate_en, exp_req);
  endtask

  task automatic t_pulse();
    int ones = 0;
    bus_write(8'h24, 32'h200);
    bus_write(8'h28, 32'h200);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      #1;
      if (gate_en[9]) ones++;
    end
    check(ones == 2, "R9 pulse width kept", 64'(ones), 64'd2);
  endtask

  initial begin
    exp_req = BOOT;
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    t_reset();
    t_set_clear();
    t_mapping();
    t_readback();
    t_lag();
    t_ro_writes();
    t_pulse();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(20ns * 20000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule